// File: doc/BRIEF.md
# Parallel Parzen-Window Density Estimator

This block builds a one-dimensional Parzen-window density estimate over 256 discrete bins. The bins are split into eight contiguous groups, each owned by one replicated weighting kernel. A 32-bit sample taken from a valid/ready stream is broadcast to all eight kernels at the same time. Each kernel then walks its own 32 bins, one bin per cycle. For each bin it forms the distance to the bin centre, turns that distance into a fixed-point window weight and adds the weight into a saturating 32-bit accumulator. As a result, a sample is finished in 32 cycles rather than 256.

A start pulse opens an iteration. It clears every accumulator and captures the window width. The block then takes a fixed batch of samples and raises done once the last of them has been folded in. The estimate is read back one bin at a time through an indexed read port that has a latency of one cycle.

Top module: `parzen_pdf`

## Requirements
- R1: While reset is held and after it is released, in_ready and done are low and rd_data is zero.
- R2: A start pulse clears all 256 accumulators and captures win_width. From the next cycle on, in_ready is high until a sample is taken.
- R3: A sample is taken on a clock edge where in_valid and in_ready are both high. in_ready then stays low for exactly 32 cycles.
- R4: Bin b has centre c = 16*b. For window width W, let d = |sample - c|. The weight is W*W - d*d when d < W and zero otherwise, with all values unsigned.
- R5: Each accepted sample adds its weight into every one of the 256 bins. Bins whose weight is zero are unchanged.
- R6: Accumulators saturate at 2^32-1 and never wrap.
- R7: done rises on the clock edge that writes the final bin update of the BATCH-th sample. It stays high, with in_ready low, until the next start. The default BATCH is 512.
- R8: rd_data shows the accumulator selected by rd_addr (an 8-bit bin index) as it stood one clock edge earlier.
- R9: in_valid while in_ready is low, including after done, is ignored and leaves the accumulators unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an iteration: clear the bins and capture the window width |
| win_width | input | 16 | Window half-width W, captured on start |
| in_valid | input | 1 | Sample present |
| in_data | input | 32 | Sample value |
| in_ready | output | 1 | Block can take a sample |
| done | output | 1 | Batch complete |
| rd_addr | input | 8 | Bin index to read |
| rd_data | output | 32 | Accumulated value of the addressed bin |

## Verification
The main function is exercised with several batches. One uses a narrow window and a slowly moving sample, so only a few neighbouring bins change; this tells apart errors in bin centre placement and kernel ownership. Another uses a wide window and spreading samples, so contributions cross the boundaries between kernels and sum from many samples. A third repeats a sample with the largest window, which drives bins into saturation. A fourth places every sample far above all bin centres; this separates a correct zero weight from a wrapped distance. Directed checks cover the handshake timing, the moment done rises, clearing by start, and samples offered while in_ready is low.

// File: rtl/parzen_pdf.sv
module parzen_pdf #(
  parameter int NUM_KERN   = 8,
  parameter int BINS_PER_K = 32,
  parameter int SMP_W      = 32,
  parameter int WIN_W      = 16,
  parameter int ACC_W      = 32,
  parameter int CTR_SHIFT  = 4,
  parameter int BATCH      = 512
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     start,
  input  logic [WIN_W-1:0]                         win_width,
  input  logic                                     in_valid,
  input  logic [SMP_W-1:0]                         in_data,
  output logic                                     in_ready,
  output logic                                     done,
  input  logic [$clog2(NUM_KERN*BINS_PER_K)-1:0]   rd_addr,
  output logic [ACC_W-1:0]                         rd_data
);
  localparam int NBINS = NUM_KERN * BINS_PER_K;
  localparam int AW    = $clog2(NBINS);
  localparam int JW    = $clog2(BINS_PER_K);
  localparam int KW    = $clog2(NUM_KERN);
  localparam int CW    = $clog2(BATCH + 1);

  logic              run_q, busy_q, done_q;
  logic [JW-1:0]     j_q;
  logic [CW-1:0]     cnt_q;
  logic [WIN_W-1:0]  win_q;
  logic [SMP_W-1:0]  smp_q;
  logic [ACC_W-1:0]  acc [NBINS];
  logic [ACC_W-1:0]  wgt [NUM_KERN];

  assign in_ready = run_q && !busy_q && !done_q;
  assign done     = done_q;

  wire take    = in_valid && in_ready;
  wire last_j  = (j_q == JW'(BINS_PER_K - 1));

  for (genvar k = 0; k < NUM_KERN; k++) begin : g_kern
    logic [SMP_W-1:0] ctr, absd;
    logic [WIN_W-1:0] dl;
    assign ctr  = SMP_W'({KW'(k), j_q}) << CTR_SHIFT;
    assign absd = (smp_q >= ctr) ? smp_q - ctr : ctr - smp_q;
    assign dl   = absd[WIN_W-1:0];
    assign wgt[k] = (absd < SMP_W'(win_q))
                  ? ACC_W'(win_q) * ACC_W'(win_q) - ACC_W'(dl) * ACC_W'(dl)
                  : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      j_q    <= '0;
      cnt_q  <= '0;
      win_q  <= '0;
      smp_q  <= '0;
      for (int b = 0; b < NBINS; b++) acc[b] <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      j_q    <= '0;
      cnt_q  <= '0;
      win_q  <= win_width;
      for (int b = 0; b < NBINS; b++) acc[b] <= '0;
    end else if (busy_q) begin
      for (int k = 0; k < NUM_KERN; k++) begin
        logic [ACC_W:0] s;
        s = {1'b0, acc[k*BINS_PER_K + int'(j_q)]} + {1'b0, wgt[k]};
        acc[k*BINS_PER_K + int'(j_q)] <= s[ACC_W] ? '1 : s[ACC_W-1:0];
      end
      j_q <= j_q + 1'b1;
      if (last_j) begin
        busy_q <= 1'b0;
        if (cnt_q == CW'(BATCH)) done_q <= 1'b1;
      end
    end else if (take) begin
      smp_q  <= in_data;
      busy_q <= 1'b1;
      j_q    <= '0;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= acc[rd_addr];
  end

  // R3: an accepted sample closes the port on the next cycle
  a_r3_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    take && !start |=> !in_ready);
  // R2: start leaves the edge bins cleared
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> acc[0] == '0 && acc[NBINS-1] == '0);
  // R6: within an iteration a bin never goes down
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> acc[NBINS-1] >= $past(acc[NBINS-1]) && acc[0] >= $past(acc[0]));
  // R7: done holds until start
  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
  // R7: no sample taken once done
  a_r7_closed_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);
  // R7: count never exceeds the batch
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(BATCH));
endmodule

// File: tb/parzen_pdf_tb.sv
module parzen_pdf_tb;
  localparam int BATCH = 8;
  localparam int NB    = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] win_width = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, done;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int n_vec = 0;
  int n_bad = 0;
  longint model [NB];

  always #2.5 clk = ~clk;

  parzen_pdf #(.BATCH(BATCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .win_width(win_width),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .done(done), .rd_addr(rd_addr), .rd_data(rd_data));

  // {window, first sample, step between samples}
  localparam logic [79:0] VEC [4] = '{
    {16'd40,    32'd1000,       32'd7},
    {16'd300,   32'd3000,       32'd97},
    {16'hFFFF,  32'd2048,       32'd0},
    {16'd20,    32'hFFFF_0000,  32'd1}
  };

  task automatic check(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint weight(input longint s, input int b, input longint w);
    longint c, d;
    c = longint'(b) * 16;
    d = (s >= c) ? s - c : c - s;
    return (d < w) ? w * w - d * d : 0;
  endfunction

  task automatic do_start(input logic [15:0] w);
    @(negedge clk);
    win_width = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int b = 0; b < NB; b++) model[b] = 0;
  endtask

  task automatic send(input logic [31:0] s, input bit last, input longint w);
    bit ok_busy;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = s;
    @(negedge clk);
    in_valid = 1'b0;
    ok_busy = 1'b1;
    for (int k = 1; k <= 32; k++) begin
      if (in_ready || done) ok_busy = 1'b0;
      if (k < 32) @(negedge clk);
    end
    @(negedge clk);
    check("R3 ready low 32 cycles", ok_busy, 1);
    check("R7 done timing", done, last);
    check("R3 ready back", in_ready, !last);
    for (int b = 0; b < NB; b++) begin
      model[b] += weight(longint'(s), b, w);
      if (model[b] > 64'hFFFF_FFFF) model[b] = 64'hFFFF_FFFF;
    end
  endtask

  task automatic read_all(input string req);
    for (int b = 0; b < NB; b++) begin
      rd_addr = b[7:0];
      @(negedge clk);
      check(req, rd_data, model[b]);
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready in reset", in_ready, 0);
    check("R1 done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", in_ready, 0);
    check("R1 rd_data after reset", rd_data, 0);

    // R4 R5 R6 R8: table of batches
    foreach (VEC[v]) begin
      do_start(VEC[v][79:64]);
      check("R2 ready after start", in_ready, 1);
      for (int i = 0; i < BATCH; i++)
        send(VEC[v][63:32] + VEC[v][31:0] * i, i == BATCH - 1, longint'(VEC[v][79:64]));
      read_all("R5 bin value");
    end

    // R9: offers after done are ignored
    in_valid = 1'b1; in_data = 32'd2048;
    repeat (40) @(negedge clk);
    in_valid = 1'b0;
    check("R9 done held", done, 1);
    read_all("R9 bins unchanged");

    // R2: start clears every bin
    do_start(16'd50);
    read_all("R2 cleared");

    // R8: latency, address changes each cycle
    send(32'd512, 1'b0, 50);
    rd_addr = 8'd32;
    @(negedge clk);
    rd_addr = 8'd0;
    check("R8 one-cycle latency", rd_data, model[32]);
    @(negedge clk);
    check("R8 next address", rd_data, model[0]);
    check("R4 centre weight", model[32], 2500);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule